// File: doc/BRIEF.md
# Single-Precision Float to Signed Integer Converter

This block turns a 32-bit binary floating-point word into a signed 32-bit two's-complement integer. It splits the word into sign, biased exponent and fraction, puts back the hidden leading one for normal numbers, and aligns the significand to a fixed binary point. It then rounds the result in one of four directions. A 2-bit control code, sampled with each operand, picks the direction.

The result is registered and comes out with a valid strobe one clock after the input strobe. A new operand can be accepted every cycle. Two flags come with each result. The invalid flag marks operands that have no integer image: infinities, NaNs and values that are out of range after rounding. The inexact flag marks results that dropped nonzero fraction bits. Zeros of either sign, denormals and the most negative integer each have a defined result.

Top module: `fp32_to_int`

## Requirements
- R1: `out_vld` is high in the cycle after each cycle with `in_vld` high, back-to-back operands included, and low otherwise. A synchronous reset clears `out_vld`, `out_int`, `out_invalid` and `out_inexact`.
- R2: The operand holds the sign in bit 31, the exponent in bits 30:23 with a bias of 127, and the fraction in bits 22:0 under an implied leading one. Values that are already whole convert exactly with both flags low. For example, 0x45AC0000 gives 5504 and 0xC4800000 gives -1024.
- R3: Rounding code 00 rounds to the nearest integer and sends exact halves to the even neighbour. For example, 5.64 gives 6, 2.5 gives 2, 3.5 gives 4 and -2.5 gives -2.
- R4: Rounding code 01 rounds toward minus infinity. For example, 1.75 gives 1 and -1.25 gives -2.
- R5: Rounding code 10 rounds toward plus infinity. For example, 1.25 gives 2 and -1.75 gives -1.
- R6: Rounding code 11 truncates toward zero. For example, -1.75 gives -1 and 10.75 gives 10.
- R7: `out_inexact` is high exactly when nonzero bits below the integer point were dropped and the result is not invalid.
- R8: An exponent field of 0 with a zero fraction is a zero of either sign. It converts to 0 with both flags low.
- R9: An exponent field of 0 with a nonzero fraction is a denormal. It converts to 0, except that code 01 gives -1 for a negative denormal and code 10 gives +1 for a positive one. `out_inexact` is always high for a denormal.
- R10: An exponent field of all ones (infinity or NaN) gives 0x80000000 with `out_invalid` high and `out_inexact` low.
- R11: A rounded value above 2147483647 or below -2147483648 gives 0x80000000 with `out_invalid` high. -2^31 itself (0xCF000000) is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operand strobe |
| in_bits | input | 32 | Floating-point operand |
| in_rmode | input | 2 | Rounding code: 00 nearest-even, 01 down, 10 up, 11 toward zero |
| out_vld | output | 1 | Result strobe, one cycle after `in_vld` |
| out_int | output | 32 | Signed integer result |
| out_invalid | output | 1 | No integer image: infinity, NaN or out of range |
| out_inexact | output | 1 | Nonzero bits were discarded |

## Verification
A wrong alignment shift or a misplaced guard bit appears at the ports one cycle after the operand strobe. It shows as an integer off by a power of two or off by one near the halfway points. A misclassified exponent field shows in the same cycle as a wrong flag pair on zeros, denormals, infinities or NaNs. The directed cases sit at each of these points: exact halves, values just above and below an integer, the three edges of the integer range, and every special encoding under each rounding code. Because of this, a single wrong decision in the datapath changes a sampled result.

// File: rtl/fp2i_pkg.sv
package fp2i_pkg;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_SUB  = 3'd1,
    CLS_NORM = 3'd2,
    CLS_INF  = 3'd3,
    CLS_NAN  = 3'd4
  } fclass_e;

endpackage

// File: rtl/fp2i_unpack.sv
module fp2i_unpack
  import fp2i_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = EXP_W + FRAC_W + 1,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int E_W    = EXP_W + 2
) (
  input  logic [WORD_W-1:0]    word,
  output logic                 sign,
  output logic signed [E_W-1:0] e_unb,
  output logic [SIG_W-1:0]     sig,
  output fclass_e              cls
);

  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_zero;
  logic              exp_ones;
  logic              frac_zero;

  assign sign   = word[WORD_W-1];
  assign exp_f  = word[FRAC_W +: EXP_W];
  assign frac_f = word[FRAC_W-1:0];

  assign exp_zero  = (exp_f == '0);
  assign exp_ones  = &exp_f;
  assign frac_zero = (frac_f == '0);

  // hidden bit is one only for a nonzero exponent field
  assign sig   = {~exp_zero, frac_f};
  assign e_unb = $signed(E_W'(exp_f)) - $signed(E_W'(BIAS));

  always_comb begin
    if (exp_zero)      cls = frac_zero ? CLS_ZERO : CLS_SUB;
    else if (exp_ones) cls = frac_zero ? CLS_INF  : CLS_NAN;
    else               cls = CLS_NORM;
  end

endmodule

// File: rtl/fp2i_align.sv
module fp2i_align #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int INT_W  = 32,
  localparam int SIG_W = FRAC_W + 1,
  localparam int E_W   = EXP_W + 2,
  localparam int FB    = FRAC_W + 2,
  localparam int FIX_W = INT_W + FB,
  localparam int SH_W  = $clog2(INT_W + 2)
) (
  input  logic signed [E_W-1:0] e_unb,
  input  logic [SIG_W-1:0]      sig,
  output logic [INT_W-1:0]      int_part,
  output logic                  rnd,
  output logic                  stk,
  output logic                  big
);

  // below E_MIN the value is under one half: only sticky survives
  localparam logic signed [E_W-1:0] E_MIN = -2;
  localparam logic signed [E_W-1:0] E_MAX = INT_W - 1;

  logic signed [E_W-1:0] sh_full;
  logic [SH_W-1:0]       sh;
  logic [FIX_W-1:0]      fixed;

  assign sh_full = e_unb - E_MIN;
  assign sh      = sh_full[SH_W-1:0];

  always_comb begin
    int_part = '0;
    rnd      = 1'b0;
    stk      = 1'b0;
    big      = 1'b0;
    fixed    = '0;
    if (e_unb > E_MAX) begin
      big = 1'b1;
    end else if (e_unb < E_MIN) begin
      stk = |sig;
    end else begin
      fixed    = FIX_W'(sig) << sh;
      int_part = fixed[FIX_W-1 -: INT_W];
      rnd      = fixed[FB-1];
      stk      = |fixed[FB-2:0];
    end
  end

endmodule

// File: rtl/fp2i_round.sv
module fp2i_round
  import fp2i_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  logic             sign,
  input  fclass_e          cls,
  input  logic [1:0]       rmode,
  input  logic [INT_W-1:0] int_part,
  input  logic             rnd,
  input  logic             stk,
  input  logic             big,
  output logic [INT_W-1:0] res,
  output logic             inv,
  output logic             inx
);

  localparam logic [INT_W:0]   LIM_POS = {2'b00, {(INT_W-1){1'b1}}};
  localparam logic [INT_W:0]   LIM_NEG = {2'b01, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] INT_MIN = {1'b1, {(INT_W-1){1'b0}}};

  logic             inc;
  logic             lost;
  logic [INT_W:0]   mag;
  logic             over;
  logic             special;
  logic [INT_W-1:0] signed_val;

  assign lost = rnd | stk;

  always_comb begin
    case (rmode_e'(rmode))
      RM_NEAR: inc = rnd & (stk | int_part[0]);
      RM_DOWN: inc = sign & lost;
      RM_UP:   inc = ~sign & lost;
      default: inc = 1'b0;
    endcase
  end

  assign mag        = {1'b0, int_part} + (INT_W+1)'(inc);
  assign over       = big | (sign ? (mag > LIM_NEG) : (mag > LIM_POS));
  assign special    = (cls == CLS_INF) | (cls == CLS_NAN);
  assign signed_val = sign ? (~mag[INT_W-1:0] + 1'b1) : mag[INT_W-1:0];

  assign inv = special | over;
  assign inx = ~inv & lost;
  assign res = inv ? INT_MIN : signed_val;

endmodule

// File: rtl/fp32_to_int.sv
module fp32_to_int
  import fp2i_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int INT_W  = 32,
  localparam int WORD_W = EXP_W + FRAC_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [WORD_W-1:0] in_bits,
  input  logic [1:0]        in_rmode,
  output logic              out_vld,
  output logic [INT_W-1:0]  out_int,
  output logic              out_invalid,
  output logic              out_inexact
);

  localparam int SIG_W = FRAC_W + 1;
  localparam int E_W   = EXP_W + 2;

  logic                  u_sign;
  logic signed [E_W-1:0] u_e;
  logic [SIG_W-1:0]      u_sig;
  fclass_e               u_cls;
  logic [INT_W-1:0]      a_int;
  logic                  a_rnd;
  logic                  a_stk;
  logic                  a_big;
  logic [INT_W-1:0]      r_res;
  logic                  r_inv;
  logic                  r_inx;

  fp2i_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
    .word  (in_bits),
    .sign  (u_sign),
    .e_unb (u_e),
    .sig   (u_sig),
    .cls   (u_cls)
  );

  fp2i_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_align (
    .e_unb    (u_e),
    .sig      (u_sig),
    .int_part (a_int),
    .rnd      (a_rnd),
    .stk      (a_stk),
    .big      (a_big)
  );

  fp2i_round #(.INT_W(INT_W)) u_round (
    .sign     (u_sign),
    .cls      (u_cls),
    .rmode    (in_rmode),
    .int_part (a_int),
    .rnd      (a_rnd),
    .stk      (a_stk),
    .big      (a_big),
    .res      (r_res),
    .inv      (r_inv),
    .inx      (r_inx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld     <= 1'b0;
      out_int     <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_int     <= r_res;
        out_invalid <= r_inv;
        out_inexact <= r_inx;
      end
    end
  end

endmodule

// File: rtl/fp2i_chk.sv
module fp2i_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int INT_W  = 32,
  localparam int WORD_W = EXP_W + FRAC_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              in_vld,
  input logic [WORD_W-1:0] in_bits,
  input logic [1:0]        in_rmode,
  input logic              out_vld,
  input logic [INT_W-1:0]  out_int,
  input logic              out_invalid,
  input logic              out_inexact
);

  localparam logic [INT_W-1:0] INT_MIN = {1'b1, {(INT_W-1){1'b0}}};

  logic [EXP_W-1:0]  c_exp;
  logic [FRAC_W-1:0] c_frac;
  assign c_exp  = in_bits[FRAC_W +: EXP_W];
  assign c_frac = in_bits[FRAC_W-1:0];

  AST_RST_CLEARS: assert property (@(posedge clk)
    rst |=> !out_vld && out_int == '0 && !out_invalid && !out_inexact); // R1

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld); // R1

  AST_NO_SPURIOUS_VLD: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld); // R1

  AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (rst)
    in_vld && c_exp == '0 && c_frac == '0
      |=> out_int == '0 && !out_invalid && !out_inexact); // R8

  AST_DENORM_INEXACT: assert property (@(posedge clk) disable iff (rst)
    in_vld && c_exp == '0 && c_frac != '0
      |=> out_inexact && !out_invalid); // R9

  AST_SPECIAL_INVALID: assert property (@(posedge clk) disable iff (rst)
    in_vld && (&c_exp) |=> out_invalid && out_int == INT_MIN); // R10

  AST_INVALID_VALUE: assert property (@(posedge clk) disable iff (rst)
    out_vld && out_invalid |-> out_int == INT_MIN && !out_inexact); // R7

  AST_TRUNC_SIGN: assert property (@(posedge clk) disable iff (rst)
    in_vld && in_rmode == 2'b11 && !in_bits[WORD_W-1] && !(&c_exp)
      |=> !out_int[INT_W-1] || out_invalid); // R6

endmodule

bind fp32_to_int fp2i_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_vld      (in_vld),
  .in_bits     (in_bits),
  .in_rmode    (in_rmode),
  .out_vld     (out_vld),
  .out_int     (out_int),
  .out_invalid (out_invalid),
  .out_inexact (out_inexact)
);

// File: tb/fp32_to_int_tb.sv
module fp32_to_int_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_vld;
  logic [31:0] in_bits;
  logic [1:0]  in_rmode;
  logic        out_vld;
  logic [31:0] out_int;
  logic        out_invalid;
  logic        out_inexact;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  localparam logic [1:0] NEAR = 2'b00, DOWN = 2'b01, UP = 2'b10, TZ = 2'b11;

  always #2 clk = ~clk;

  fp32_to_int u_dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_bits(in_bits), .in_rmode(in_rmode),
    .out_vld(out_vld), .out_int(out_int), .out_invalid(out_invalid), .out_inexact(out_inexact)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp_v);
    end
  endtask

  // drive one operand, sample result one cycle later
  task automatic conv(input string req, input logic [31:0] bits, input logic [1:0] rm,
                      input logic [31:0] exp_v, input logic exp_inv, input logic exp_inx);
    @(negedge clk);
    in_vld = 1'b1; in_bits = bits; in_rmode = rm;
    @(negedge clk);
    in_vld = 1'b0;
    check(req, "vld", {31'd0, out_vld}, 32'd1);
    check(req, $sformatf("int %h rm%0d", bits, rm), out_int, exp_v);
    check(req, $sformatf("invalid %h", bits), {31'd0, out_invalid}, {31'd0, exp_inv});
    check(req, $sformatf("inexact %h", bits), {31'd0, out_inexact}, {31'd0, exp_inx});
  endtask

  task automatic t_reset();
    rst = 1'b1; in_vld = 1'b0; in_bits = '0; in_rmode = '0;
    repeat (3) @(negedge clk);
    check("R1", "reset vld", {31'd0, out_vld}, 32'd0);
    check("R1", "reset int", out_int, 32'd0);
    check("R1", "reset flags", {30'd0, out_invalid, out_inexact}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_r1_stream();
    @(negedge clk);
    in_vld = 1'b1; in_bits = 32'h3F800000; in_rmode = NEAR;
    @(negedge clk);
    check("R1", "stream vld a", {31'd0, out_vld}, 32'd1);
    check("R1", "stream int a", out_int, 32'd1);
    in_bits = 32'hC4800000;
    @(negedge clk);
    in_vld = 1'b0;
    check("R1", "stream vld b", {31'd0, out_vld}, 32'd1);
    check("R1", "stream int b", out_int, -32'sd1024);
    @(negedge clk);
    check("R1", "idle vld", {31'd0, out_vld}, 32'd0);
  endtask

  task automatic t_r2_exact();
    conv("R2", 32'h45AC0000, NEAR, 32'd5504, 0, 0);
    conv("R2", 32'hC4800000, TZ, -32'sd1024, 0, 0);
    conv("R2", 32'h4B7FFFFF, UP, 32'd16777215, 0, 0);
    conv("R2", 32'h4B800001, DOWN, 32'd16777218, 0, 0);
  endtask

  task automatic t_r3_nearest();
    conv("R3", 32'h40B47AE1, NEAR, 32'd6, 0, 1);
    conv("R3", 32'h40200000, NEAR, 32'd2, 0, 1);
    conv("R3", 32'h40600000, NEAR, 32'd4, 0, 1);
    conv("R3", 32'hC0200000, NEAR, -32'sd2, 0, 1);
    conv("R3", 32'h3F000000, NEAR, 32'd0, 0, 1);
    conv("R3", 32'h3FC00000, NEAR, 32'd2, 0, 1);
    conv("R3", 32'hC2A76666, NEAR, -32'sd84, 0, 1);
  endtask

  task automatic t_r4_down();
    conv("R4", 32'h3FE00000, DOWN, 32'd1, 0, 1);
    conv("R4", 32'hBFA00000, DOWN, -32'sd2, 0, 1);
    conv("R4", 32'hC2A76666, DOWN, -32'sd84, 0, 1);
  endtask

  task automatic t_r5_up();
    conv("R5", 32'h3FA00000, UP, 32'd2, 0, 1);
    conv("R5", 32'hBFE00000, UP, -32'sd1, 0, 1);
    conv("R5", 32'h3E800000, UP, 32'd1, 0, 1);
    conv("R5", 32'hC2A76666, UP, -32'sd83, 0, 1);
  endtask

  task automatic t_r6_zero();
    conv("R6", 32'hBFE00000, TZ, -32'sd1, 0, 1);
    conv("R6", 32'h412C0000, TZ, 32'd10, 0, 1);
    conv("R6", 32'h3FE00000, TZ, 32'd1, 0, 1);
  endtask

  task automatic t_r7_inexact();
    conv("R7", 32'h412C0000, NEAR, 32'd11, 0, 1);
    conv("R7", 32'h41200000, NEAR, 32'd10, 0, 0);
    conv("R7", 32'h3E800000, NEAR, 32'd0, 0, 1);
  endtask

  task automatic t_r8_zeros();
    conv("R8", 32'h00000000, UP, 32'd0, 0, 0);
    conv("R8", 32'h80000000, DOWN, 32'd0, 0, 0);
  endtask

  task automatic t_r9_denormal();
    conv("R9", 32'h00000001, NEAR, 32'd0, 0, 1);
    conv("R9", 32'h00000001, UP, 32'd1, 0, 1);
    conv("R9", 32'h80000001, DOWN, -32'sd1, 0, 1);
    conv("R9", 32'h80000001, UP, 32'd0, 0, 1);
    conv("R9", 32'h007FFFFF, TZ, 32'd0, 0, 1);
  endtask

  task automatic t_r10_special();
    conv("R10", 32'h7F800000, NEAR, 32'h80000000, 1, 0);
    conv("R10", 32'hFF800000, DOWN, 32'h80000000, 1, 0);
    conv("R10", 32'h7FC00000, UP, 32'h80000000, 1, 0);
    conv("R10", 32'hFFFFFFFF, TZ, 32'h80000000, 1, 0);
  endtask

  task automatic t_r11_range();
    conv("R11", 32'h4F000000, NEAR, 32'h80000000, 1, 0);
    conv("R11", 32'hCF000000, NEAR, 32'h80000000, 0, 0);
    conv("R11", 32'h4EFFFFFF, UP, 32'h7FFFFF80, 0, 0);
    conv("R11", 32'hCF000001, TZ, 32'h80000000, 1, 0);
    conv("R11", 32'h7F7FFFFF, DOWN, 32'h80000000, 1, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_r1_stream();
    t_r2_exact();
    t_r3_nearest();
    t_r4_down();
    t_r5_up();
    t_r6_zero();
    t_r7_inexact();
    t_r8_zeros();
    t_r9_denormal();
    t_r10_special();
    t_r11_range();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule